// File: doc/BRIEF.md
# Calendar Shadow Register Synchronizer

This block moves the subseconds, time and date words of a real-time clock from the slow RTC clock domain into the bus clock domain. On every second RTC clock edge, unless the device is in a low-power state, the RTC side latches all three live words into one staging set and toggles a request bit. The bus side passes that toggle through a flop chain, detects the change and loads the three staging words into the shadow registers in a single bus cycle. The same bus cycle raises a ready flag, which software clears with a strobe.

Reads normally return the shadow words. With the bypass control high, the read ports show the live calendar words directly. No handshake is needed for that path. A read of the subseconds word holds the time and date shadows until the date word is read, so a read of all three words stays consistent. The read ports are plain registered values with no valid/ready pair: they are always readable and never apply back-pressure, and the read strobes only steer the hold. The staging words stay stable for two RTC periods and the crossing takes about three bus cycles, so the bus clock must run at least seven times as fast as the RTC clock.

Top module: `cal_shadow_sync`

## Requirements
- R1: When low power is not asserted, the block captures the live subseconds, time and date words together on every second RTC clock rising edge. A few bus cycles later all three shadow words are updated in the same bus cycle. At no other time do the shadows change.
- R2: Each capture that reaches the bus domain sets ready_o to 1.
- R3: While lowpwr_i is high at an RTC edge, no capture takes place. The shadow words and ready_o stay unchanged for as long as it remains high.
- R4: After lowpwr_i falls, a fresh capture is taken within two RTC rising edges. It appears on the read ports no later than five bus cycles after the second of those edges.
- R5: With bypass_i = 1 the read ports show live_sub_i, live_time_i and live_date_i combinationally. With bypass_i = 0 they show the shadow words.
- R6: An active-low rst_n clears the three shadow words and ready_o to 0, whatever the live inputs are.
- R7: A one-cycle flag_clr_i pulse clears ready_o on the next bus edge. If a copy lands in the same bus cycle as the clear, the copy wins and ready_o stays 1.
- R8: A rd_sub_i pulse holds the time and date shadows at their current values until a rd_date_i pulse arrives. During the hold the subseconds shadow still follows new copies. If both strobes arrive in the same cycle, rd_sub_i wins and the hold is kept.
- R9: With the bus clock at least seven times the RTC clock, the three shadow words seen in any one bus cycle always come from a single capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rtc_clk | input | 1 | RTC domain clock |
| bus_clk | input | 1 | Bus domain clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| live_sub_i | input | SUB_W | Live subseconds word (RTC domain) |
| live_time_i | input | TIME_W | Live time word (RTC domain) |
| live_date_i | input | DATE_W | Live date word (RTC domain) |
| lowpwr_i | input | 1 | Stop/standby indication, RTC domain; freezes captures |
| bypass_i | input | 1 | 1 selects live words on the read ports |
| rd_sub_i | input | 1 | Bus pulse: subseconds word is being read |
| rd_date_i | input | 1 | Bus pulse: date word is being read |
| flag_clr_i | input | 1 | Bus pulse: clear ready flag |
| sub_o | output | SUB_W | Readable subseconds word |
| time_o | output | TIME_W | Readable time word |
| date_o | output | DATE_W | Readable date word |
| ready_o | output | 1 | Fresh-copy flag, bus domain |

## Verification
The bench sets a flag clear and a copy arrival in the same bus cycle. A design that gives the clear priority shows ready_o low at the moment the new shadow appears. It also times the first refresh after leaving low power against a tight bound, which catches a design that waits a full extra period or keeps shadows stale. It drives live words that change every RTC cycle in a fixed relation to each other and samples the shadows every bus cycle. A design that crosses the words one at a time, or loads them from unstable data, breaks that relation. The bench also checks that a subseconds read holds time and date while subseconds keeps moving. A design that ignores the hold, or freezes every word, fails that check.

// File: rtl/cal_shadow_pkg.sv
package cal_shadow_pkg;
  localparam int unsigned DEF_SUB_W    = 16;
  localparam int unsigned DEF_TIME_W   = 24;
  localparam int unsigned DEF_DATE_W   = 24;
  localparam int unsigned DEF_SYNC     = 2;
  localparam int unsigned DEF_PERIOD   = 2;

  typedef enum logic {
    HOLD_OPEN = 1'b0,
    HOLD_SET  = 1'b1
  } hold_e;
endpackage

// File: rtl/cal_rtc_capture.sv
module cal_rtc_capture #(
  parameter int unsigned SUB_W       = 16,
  parameter int unsigned TIME_W      = 24,
  parameter int unsigned DATE_W      = 24,
  parameter int unsigned COPY_PERIOD = 2
) (
  input  logic              rtc_clk,
  input  logic              rst_n,
  input  logic              lowpwr_i,
  input  logic [SUB_W-1:0]  live_sub_i,
  input  logic [TIME_W-1:0] live_time_i,
  input  logic [DATE_W-1:0] live_date_i,
  output logic [SUB_W-1:0]  stg_sub_o,
  output logic [TIME_W-1:0] stg_time_o,
  output logic [DATE_W-1:0] stg_date_o,
  output logic              req_tgl_o
);
  localparam int unsigned PW = (COPY_PERIOD > 2) ? $clog2(COPY_PERIOD) : 1;
  localparam logic [PW-1:0] LAST = PW'(COPY_PERIOD - 1);

  logic [PW-1:0] phase_q;

  // Staging words and the request toggle change together on one RTC edge.
  always_ff @(posedge rtc_clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= '0;
      stg_sub_o  <= '0;
      stg_time_o <= '0;
      stg_date_o <= '0;
      req_tgl_o  <= 1'b0;
    end else if (!lowpwr_i) begin
      if (phase_q == LAST) begin
        phase_q    <= '0;
        stg_sub_o  <= live_sub_i;
        stg_time_o <= live_time_i;
        stg_date_o <= live_date_i;
        req_tgl_o  <= ~req_tgl_o;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cal_toggle_sync.sv
module cal_toggle_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic bus_clk,
  input  logic rst_n,
  input  logic tgl_i,
  output logic pulse_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= tgl_i;
      end
    end else begin : g_many
      always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], tgl_i};
      end
    end
  endgenerate

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign pulse_o = chain_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/cal_shadow_bank.sv
module cal_shadow_bank
  import cal_shadow_pkg::*;
#(
  parameter int unsigned SUB_W  = 16,
  parameter int unsigned TIME_W = 24,
  parameter int unsigned DATE_W = 24
) (
  input  logic              bus_clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [SUB_W-1:0]  stg_sub_i,
  input  logic [TIME_W-1:0] stg_time_i,
  input  logic [DATE_W-1:0] stg_date_i,
  input  logic              rd_sub_i,
  input  logic              rd_date_i,
  input  logic              flag_clr_i,
  output logic [SUB_W-1:0]  sh_sub_o,
  output logic [TIME_W-1:0] sh_time_o,
  output logic [DATE_W-1:0] sh_date_o,
  output logic              ready_o,
  output logic              hold_o
);
  hold_e hold_q;

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n)         hold_q <= HOLD_OPEN;
    else if (rd_sub_i)  hold_q <= HOLD_SET;
    else if (rd_date_i) hold_q <= HOLD_OPEN;
  end

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_sub_o  <= '0;
      sh_time_o <= '0;
      sh_date_o <= '0;
    end else if (load_i) begin
      sh_sub_o <= stg_sub_i;
      if (hold_q == HOLD_OPEN) begin
        sh_time_o <= stg_time_i;
        sh_date_o <= stg_date_i;
      end
    end
  end

  // A copy in the same cycle as a clear leaves the flag set.
  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n)          ready_o <= 1'b0;
    else if (load_i)     ready_o <= 1'b1;
    else if (flag_clr_i) ready_o <= 1'b0;
  end

  assign hold_o = (hold_q == HOLD_SET);
endmodule

// File: rtl/cal_shadow_sync.sv
module cal_shadow_sync
  import cal_shadow_pkg::*;
#(
  parameter int unsigned SUB_W       = DEF_SUB_W,
  parameter int unsigned TIME_W      = DEF_TIME_W,
  parameter int unsigned DATE_W      = DEF_DATE_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC,
  parameter int unsigned COPY_PERIOD = DEF_PERIOD
) (
  input  logic              rtc_clk,
  input  logic              bus_clk,
  input  logic              rst_n,
  input  logic [SUB_W-1:0]  live_sub_i,
  input  logic [TIME_W-1:0] live_time_i,
  input  logic [DATE_W-1:0] live_date_i,
  input  logic              lowpwr_i,
  input  logic              bypass_i,
  input  logic              rd_sub_i,
  input  logic              rd_date_i,
  input  logic              flag_clr_i,
  output logic [SUB_W-1:0]  sub_o,
  output logic [TIME_W-1:0] time_o,
  output logic [DATE_W-1:0] date_o,
  output logic              ready_o
);
  logic [SUB_W-1:0]  stg_sub, sh_sub;
  logic [TIME_W-1:0] stg_time, sh_time;
  logic [DATE_W-1:0] stg_date, sh_date;
  logic              req_tgl;
  logic              load_pulse;
  logic              hold_act;

  cal_rtc_capture #(
    .SUB_W(SUB_W), .TIME_W(TIME_W), .DATE_W(DATE_W), .COPY_PERIOD(COPY_PERIOD)
  ) u_cap (
    .rtc_clk    (rtc_clk),
    .rst_n      (rst_n),
    .lowpwr_i   (lowpwr_i),
    .live_sub_i (live_sub_i),
    .live_time_i(live_time_i),
    .live_date_i(live_date_i),
    .stg_sub_o  (stg_sub),
    .stg_time_o (stg_time),
    .stg_date_o (stg_date),
    .req_tgl_o  (req_tgl)
  );

  cal_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .bus_clk(bus_clk),
    .rst_n  (rst_n),
    .tgl_i  (req_tgl),
    .pulse_o(load_pulse)
  );

  cal_shadow_bank #(
    .SUB_W(SUB_W), .TIME_W(TIME_W), .DATE_W(DATE_W)
  ) u_bank (
    .bus_clk   (bus_clk),
    .rst_n     (rst_n),
    .load_i    (load_pulse),
    .stg_sub_i (stg_sub),
    .stg_time_i(stg_time),
    .stg_date_i(stg_date),
    .rd_sub_i  (rd_sub_i),
    .rd_date_i (rd_date_i),
    .flag_clr_i(flag_clr_i),
    .sh_sub_o  (sh_sub),
    .sh_time_o (sh_time),
    .sh_date_o (sh_date),
    .ready_o   (ready_o),
    .hold_o    (hold_act)
  );

  always_comb begin
    if (bypass_i) begin
      sub_o  = live_sub_i;
      time_o = live_time_i;
      date_o = live_date_i;
    end else begin
      sub_o  = sh_sub;
      time_o = sh_time;
      date_o = sh_date;
    end
  end
endmodule

// File: rtl/cal_shadow_sync_chk.sv
module cal_shadow_sync_chk #(
  parameter int unsigned SUB_W  = 16,
  parameter int unsigned TIME_W = 24,
  parameter int unsigned DATE_W = 24
) (
  input logic              rtc_clk,
  input logic              bus_clk,
  input logic              rst_n,
  input logic              lowpwr_i,
  input logic              flag_clr_i,
  input logic              ready_o,
  input logic              req_tgl,
  input logic              load_pulse,
  input logic              hold_act,
  input logic [SUB_W-1:0]  sh_sub,
  input logic [TIME_W-1:0] sh_time,
  input logic [DATE_W-1:0] sh_date
);
  assert_shadow_only_on_copy_R1: assert property (@(posedge bus_clk) disable iff (!rst_n)
    !load_pulse |=> ($stable(sh_sub) && $stable(sh_time) && $stable(sh_date)));

  assert_copy_sets_flag_R2: assert property (@(posedge bus_clk) disable iff (!rst_n)
    load_pulse |=> ready_o);

  assert_no_request_lowpwr_R3: assert property (@(posedge rtc_clk) disable iff (!rst_n)
    lowpwr_i |=> $stable(req_tgl));

  assert_reset_clear_R6: assert property (@(posedge bus_clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!ready_o && sh_sub == '0 && sh_time == '0 && sh_date == '0));

  assert_clear_flag_R7: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (flag_clr_i && !load_pulse) |=> !ready_o);

  assert_hold_time_date_R8: assert property (@(posedge bus_clk) disable iff (!rst_n)
    hold_act |=> ($stable(sh_time) && $stable(sh_date)));
endmodule

bind cal_shadow_sync cal_shadow_sync_chk #(
  .SUB_W(SUB_W), .TIME_W(TIME_W), .DATE_W(DATE_W)
) u_chk (
  .rtc_clk   (rtc_clk),
  .bus_clk   (bus_clk),
  .rst_n     (rst_n),
  .lowpwr_i  (lowpwr_i),
  .flag_clr_i(flag_clr_i),
  .ready_o   (ready_o),
  .req_tgl   (req_tgl),
  .load_pulse(load_pulse),
  .hold_act  (hold_act),
  .sh_sub    (sh_sub),
  .sh_time   (sh_time),
  .sh_date   (sh_date)
);

// File: tb/tb_cal_shadow_sync.sv
`timescale 1ns/1ps
module tb_cal_shadow_sync;
  localparam int SW = 16;
  localparam int TW = 24;
  localparam int DW = 24;

  logic          rtc_clk = 1'b0;
  logic          bus_clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SW-1:0] live_sub = '0;
  logic [TW-1:0] live_time = '0;
  logic [DW-1:0] live_date = '0;
  logic          lowpwr = 1'b0, bypass = 1'b0;
  logic          rd_sub = 1'b0, rd_date = 1'b0, flag_clr = 1'b0;
  logic [SW-1:0] sub_o;
  logic [TW-1:0] time_o;
  logic [DW-1:0] date_o;
  logic          ready_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4  bus_clk = ~bus_clk;   // 125 MHz
  always #32 rtc_clk = ~rtc_clk;   // 8x slower

  cal_shadow_sync dut (
    .rtc_clk(rtc_clk), .bus_clk(bus_clk), .rst_n(rst_n),
    .live_sub_i(live_sub), .live_time_i(live_time), .live_date_i(live_date),
    .lowpwr_i(lowpwr), .bypass_i(bypass), .rd_sub_i(rd_sub), .rd_date_i(rd_date),
    .flag_clr_i(flag_clr), .sub_o(sub_o), .time_o(time_o), .date_o(date_o),
    .ready_o(ready_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_bus(input int n);
    repeat (n) @(negedge bus_clk);
  endtask

  task automatic wait_rtc(input int n);
    repeat (n) @(negedge rtc_clk);
  endtask

  task automatic set_live(input logic [15:0] k);
    @(negedge rtc_clk);
    live_sub  = k;
    live_time = 24'(k) + 24'd100;
    live_date = 24'(k) + 24'd200;
  endtask

  task automatic pulse_clr();
    @(negedge bus_clk); flag_clr = 1'b1;
    @(negedge bus_clk); flag_clr = 1'b0;
  endtask

  task automatic wait_copy();
    wait_rtc(3); wait_bus(2);
  endtask

  task automatic enter_lowpwr();
    @(negedge rtc_clk); lowpwr = 1'b1;
    wait_rtc(1); wait_bus(4);
  endtask

  task automatic t_reset();
    live_sub = 16'hABCD; live_time = 24'h123456; live_date = 24'h654321;
    wait_bus(5);
    rst_n = 1'b1;
    check("R6 sub after reset", 32'(sub_o), 0);
    check("R6 time after reset", 32'(time_o), 0);
    check("R6 date after reset", 32'(date_o), 0);
    check("R6 ready after reset", 32'(ready_o), 0);
  endtask

  task automatic t_copy();
    set_live(16'h0011);
    wait_copy();
    check("R1 sub copied", 32'(sub_o), 32'h11);
    check("R1 time copied", 32'(time_o), 32'h11 + 100);
    check("R1 date copied", 32'(date_o), 32'h11 + 200);
    check("R2 ready after copy", 32'(ready_o), 1);
  endtask

  task automatic t_periodic();
    pulse_clr();
    wait_copy();
    check("R2 ready set by next periodic copy", 32'(ready_o), 1);
  endtask

  task automatic t_lowpwr();
    enter_lowpwr();
    pulse_clr();
    wait_bus(1);
    check("R7 ready cleared by strobe", 32'(ready_o), 0);
    set_live(16'h0222);
    wait_rtc(8);
    check("R3 sub frozen in low power", 32'(sub_o), 32'h11);
    check("R3 no ready in low power", 32'(ready_o), 0);
    @(negedge rtc_clk); lowpwr = 1'b0;
    wait_rtc(2); wait_bus(1);
    check("R4 sub refreshed after exit", 32'(sub_o), 32'h222);
    check("R4 date refreshed after exit", 32'(date_o), 32'h222 + 200);
  endtask

  task automatic t_bypass();
    enter_lowpwr();
    @(negedge rtc_clk);
    live_sub = 16'h5A5A; live_time = 24'hC0FFEE; live_date = 24'h0BEEF0;
    wait_bus(1);
    bypass = 1'b1;
    #1;
    check("R5 bypass sub live", 32'(sub_o), 32'h5A5A);
    check("R5 bypass time live", 32'(time_o), 32'hC0FFEE);
    check("R5 bypass date live", 32'(date_o), 32'h0BEEF0);
    bypass = 1'b0;
    #1;
    check("R5 shadow sub back", 32'(sub_o), 32'h222);
    check("R5 shadow time back", 32'(time_o), 32'h222 + 100);
    check("R5 shadow date back", 32'(date_o), 32'h222 + 200);
    @(negedge rtc_clk); lowpwr = 1'b0;
  endtask

  task automatic t_hold();
    set_live(16'h0300);
    wait_copy();
    @(negedge bus_clk); rd_sub = 1'b1;
    @(negedge bus_clk); rd_sub = 1'b0;
    set_live(16'h0400);
    wait_copy();
    check("R8 sub follows during hold", 32'(sub_o), 32'h400);
    check("R8 time held", 32'(time_o), 32'h300 + 100);
    check("R8 date held", 32'(date_o), 32'h300 + 200);
    @(negedge bus_clk); rd_date = 1'b1;
    @(negedge bus_clk); rd_date = 1'b0;
    wait_copy();
    check("R8 time released", 32'(time_o), 32'h400 + 100);
    check("R8 date released", 32'(date_o), 32'h400 + 200);
  endtask

  task automatic t_coherent();
    int bad = 0;
    set_live(16'h1000);
    wait_copy();
    fork
      for (int k = 0; k < 40; k++) set_live(16'(16'h1001 + k));
      for (int s = 0; s < 320; s++) begin
        @(negedge bus_clk);
        if (32'(time_o) != 32'(sub_o) + 100 || 32'(date_o) != 32'(sub_o) + 200) bad++;
      end
    join
    check("R9 incoherent samples", 32'(bad), 0);
  endtask

  task automatic t_collide();
    logic hit = 1'b0;
    enter_lowpwr();
    set_live(16'h0777);
    @(negedge bus_clk); flag_clr = 1'b1;
    @(negedge rtc_clk); lowpwr = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge bus_clk);
      if (sub_o == 16'h0777) begin
        hit = 1'b1;
        break;
      end
    end
    check("R7 copy reached shadow under clear", 32'(hit), 1);
    check("R7 copy beats clear", 32'(ready_o), 1);
    flag_clr = 1'b0;
  endtask

  initial begin
    t_reset();
    t_copy();
    t_periodic();
    t_lowpwr();
    t_bypass();
    t_hold();
    t_coherent();
    t_collide();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule